// File: doc/BRIEF.md
# Interlocked Byte Port Handshake Controller

This block moves bytes across a parallel port using a two-wire interlocked exchange: an active-low strobe that announces a byte (`dav_n`) and an active-high acknowledge line (`rdy`). A mode input picks the direction. In receive mode an outside source places a byte on the port and pulls the strobe low. The block takes the byte on that falling edge, pulls `rdy` low, and raises `rdy` again only after the strobe has gone high and the CPU side has taken the byte. In send mode the block places a byte on the port, pulls the strobe low, and holds it low until the peripheral pulls `rdy` low. It then releases the strobe and waits for `rdy` to rise before it starts another byte.

On the CPU side a valid/ready write channel supplies outgoing bytes and a valid/ready read channel delivers incoming ones. A one-entry buffer holds a received byte until it is read, and while that buffer is full the source is stalled through `rdy`. Both strobe inputs and the port data pass through two-flop synchronizers before any decision uses them.

The receive engine has three states. RX_OPEN: ready, `rdy` high. It goes to RX_TAKEN on a synchronized strobe fall, which captures the byte. RX_TAKEN: `rdy` low, waiting for the strobe to rise. It goes to RX_FULL when the strobe is seen high, or when the block leaves receive mode. RX_FULL: `rdy` low. It goes back to RX_OPEN once the buffer is empty.

The send engine has four states. TX_IDLE: a write is accepted here and goes to TX_SETUP. TX_SETUP: the byte is driven and the strobe is still high. It goes to TX_STROBE once `rdy` is seen high. TX_STROBE: the strobe is low. It goes to TX_RELEASE once `rdy` is seen low. TX_RELEASE: the strobe is high again. It goes back to TX_IDLE once `rdy` is seen high. Whenever send mode is dropped, the send engine returns to TX_IDLE.

Top module: `pxfer_port`

## Requirements
- R1: After reset, `dav_n_out` is 1, `rdy_out` is 1, `rd_valid` is 0, and with `mode_out` = 0, `wr_ready` is 0.
- R2: In receive mode (`mode_out` = 0), the byte on `pin_din` when `dav_n_in` falls is presented on `rd_data` with `rd_valid` = 1. The byte must be stable at the fall and held for at least two clock periods after it.
- R3: In receive mode, `rdy_out` goes low within 4 clock cycles after `dav_n_in` falls, and stays low while `dav_n_in` stays low.
- R4: While `rd_valid` is 1 in receive mode, `rdy_out` stays 0. After `dav_n_in` is high again and a read (`rd_valid` and `rd_ready` both 1 on a clock edge) empties the buffer, `rdy_out` returns to 1 within 4 cycles.
- R5: In send mode (`mode_out` = 1), a byte accepted on the write channel appears on `pin_dout` before `dav_n_out` goes low, and stays unchanged while `dav_n_out` is low.
- R6: In send mode, `dav_n_out` stays low while `rdy_in` stays high, and goes back high within 4 cycles after `rdy_in` goes low.
- R7: In send mode, `wr_ready` is 0 from an accepted write until the exchange completes with `rdy_in` high again. If `rdy_in` is low when a byte is set up, `dav_n_out` stays high until `rdy_in` rises.
- R8: `pin_oe` equals `mode_out`. In receive mode `wr_ready` is 0 and `dav_n_out` is 1. In send mode `rdy_out` is 1 and a fall of `dav_n_in` captures nothing.
- R9: A single low period of `dav_n_in` captures exactly one byte. If the CPU reads the byte while `dav_n_in` is still low, `rd_valid` stays 0 until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_out | input | 1 | 1 = send mode, 0 = receive mode |
| wr_valid | input | 1 | CPU offers a byte to send |
| wr_data | input | DW | Byte to send |
| wr_ready | output | 1 | Write is accepted on this edge |
| rd_valid | output | 1 | Received byte is held in the buffer |
| rd_data | output | DW | Received byte |
| rd_ready | input | 1 | CPU takes the received byte |
| pin_din | input | DW | Port data from the pins |
| pin_dout | output | DW | Port data to the pins |
| pin_oe | output | 1 | Drive enable for the port data pins |
| dav_n_in | input | 1 | Incoming data-available strobe, active low |
| dav_n_out | output | 1 | Outgoing data-available strobe, active low |
| rdy_in | input | 1 | Incoming ready from the peripheral |
| rdy_out | output | 1 | Outgoing ready to the source |

## Verification
The assertions assume that the strobe and ready inputs follow the interlock. A source does not pull `dav_n_in` low again until it has seen `rdy_out` high. A peripheral answers the strobe with `rdy_in` only in the order low, then high. The assertions also assume that `mode_out` changes only when no exchange is in progress. They relate output edges to input levels a fixed three edges earlier, so they depend on inputs that stay settled across a full clock period. The bench drives every input on the falling clock edge and switches mode only after both engines are idle. It holds each incoming byte for several cycles after its strobe fall, so all stimulus stays inside those limits.

// File: rtl/pxfer_pkg.sv
package pxfer_pkg;

    typedef enum logic [1:0] {
        RX_OPEN  = 2'd0,
        RX_TAKEN = 2'd1,
        RX_FULL  = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_SETUP   = 2'd1,
        TX_STROBE  = 2'd2,
        TX_RELEASE = 2'd3
    } tx_state_t;

endpackage

// File: rtl/pxfer_sync.sv
module pxfer_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pxfer_rx.sv
module pxfer_rx
    import pxfer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dav_s,
    input  logic [DW-1:0] din_s,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rdy_out
);
    rx_state_t state, nstate;
    logic dav_prev;
    logic buf_v;
    logic [DW-1:0] buf_d;
    logic fall, capture, take;

    assign fall    = dav_prev & ~dav_s;
    assign capture = en && (state == RX_OPEN) && fall;
    assign take    = buf_v && rd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RX_OPEN;
            dav_prev <= 1'b1;
        end else begin
            state    <= nstate;
            dav_prev <= dav_s;
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            RX_OPEN:  if (capture) nstate = RX_TAKEN;
            RX_TAKEN: if (!en || dav_s) nstate = RX_FULL;
            RX_FULL:  if (!buf_v || take) nstate = RX_OPEN;
            default:  nstate = RX_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_v <= 1'b0;
            buf_d <= '0;
        end else if (capture) begin
            buf_v <= 1'b1;
            buf_d <= din_s;
        end else if (take) begin
            buf_v <= 1'b0;
        end
    end

    always_comb begin
        rd_valid = buf_v;
        rd_data  = buf_d;
        rdy_out  = !en || (state == RX_OPEN);
    end
endmodule

// File: rtl/pxfer_tx.sv
module pxfer_tx
    import pxfer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          rdy_s,
    output logic          dav_n_out,
    output logic [DW-1:0] dout
);
    tx_state_t state, nstate;
    logic accept;

    assign accept = en && (state == TX_IDLE) && wr_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            TX_IDLE:    if (accept) nstate = TX_SETUP;
            TX_SETUP:   if (!en) nstate = TX_IDLE; else if (rdy_s) nstate = TX_STROBE;
            TX_STROBE:  if (!en) nstate = TX_IDLE; else if (!rdy_s) nstate = TX_RELEASE;
            TX_RELEASE: if (!en || rdy_s) nstate = TX_IDLE;
            default:    nstate = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dout <= '0;
        else if (accept) dout <= wr_data;
    end

    always_comb begin
        wr_ready  = en && (state == TX_IDLE);
        dav_n_out = (state != TX_STROBE);
    end
endmodule

// File: rtl/pxfer_port.sv
module pxfer_port #(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_out,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          rd_ready,
    input  logic [DW-1:0] pin_din,
    output logic [DW-1:0] pin_dout,
    output logic          pin_oe,
    input  logic          dav_n_in,
    output logic          dav_n_out,
    input  logic          rdy_in,
    output logic          rdy_out
);
    localparam logic [DW-1:0] DATA_INIT = '0;

    logic          dav_s, rdy_s;
    logic [DW-1:0] din_s;

    pxfer_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_dav_sync (
        .clk(clk), .rst_n(rst_n), .d(dav_n_in), .q(dav_s)
    );
    pxfer_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_s)
    );
    pxfer_sync #(.W(DW), .STAGES(SYNC_STAGES), .INIT(DATA_INIT)) u_din_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_din), .q(din_s)
    );

    pxfer_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(!mode_out),
        .dav_s(dav_s), .din_s(din_s),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rdy_out(rdy_out)
    );

    pxfer_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(mode_out),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rdy_s(rdy_s), .dav_n_out(dav_n_out), .dout(pin_dout)
    );

    assign pin_oe = mode_out;
endmodule

// File: rtl/pxfer_port_chk.sv
module pxfer_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_out,
    input logic          wr_ready,
    input logic          rd_valid,
    input logic [DW-1:0] pin_dout,
    input logic          pin_oe,
    input logic          dav_n_in,
    input logic          dav_n_out,
    input logic          rdy_in,
    input logic          rdy_out
);
    assert_capture_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(dav_n_in, 3) == 1'b0);

    assert_rdy_low_while_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !mode_out) |-> !rdy_out);

    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dav_n_out |-> $stable(pin_dout));

    assert_release_after_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dav_n_out) && $past(pin_oe)) |-> $past(rdy_in, 3) == 1'b0);

    assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> dav_n_out);

    assert_send_mode_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> rdy_out);

    assert_recv_mode_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> (dav_n_out && !wr_ready));
endmodule

bind pxfer_port pxfer_port_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_out(mode_out), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .pin_dout(pin_dout), .pin_oe(pin_oe),
    .dav_n_in(dav_n_in), .dav_n_out(dav_n_out), .rdy_in(rdy_in), .rdy_out(rdy_out)
);

// File: tb/sim_pxfer_port.sv
module sim_pxfer_port;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_out = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_ready = 1'b0;
    logic [DW-1:0] pin_din = '0;
    logic [DW-1:0] pin_dout;
    logic          pin_oe;
    logic          dav_n_in = 1'b1;
    logic          dav_n_out;
    logic          rdy_in = 1'b1;
    logic          rdy_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pxfer_port #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_out(mode_out),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .pin_din(pin_din), .pin_dout(pin_dout), .pin_oe(pin_oe),
        .dav_n_in(dav_n_in), .dav_n_out(dav_n_out),
        .rdy_in(rdy_in), .rdy_out(rdy_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_read();
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(dav_n_out === 1'b1, "R1 dav_n_out", dav_n_out, 1);
        chk(rdy_out === 1'b1, "R1 rdy_out", rdy_out, 1);
        chk(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(wr_ready === 1'b0, "R1 wr_ready", wr_ready, 0);
    endtask

    // Receive one byte; CPU reads late (after strobe rises) to test the stall.
    task automatic t_rx_byte(input logic [DW-1:0] b);
        pin_din = b;
        dav_n_in = 1'b0;
        for (int i = 0; i < 4 && rdy_out !== 1'b0; i++) @(negedge clk);
        chk(rdy_out === 1'b0, "R3 rdy falls", rdy_out, 0);
        chk(rd_valid === 1'b1 && rd_data === b, "R2 captured byte", rd_data, b);
        cycles(4);
        chk(rdy_out === 1'b0, "R3 rdy held while dav low", rdy_out, 0);
        dav_n_in = 1'b1;
        pin_din = ~b;
        cycles(8);
        chk(rdy_out === 1'b0, "R4 rdy low while buffer full", rdy_out, 0);
        chk(rd_data === b, "R2 buffer kept", rd_data, b);
        cpu_read();
        chk(rd_valid === 1'b0, "R4 buffer emptied", rd_valid, 0);
        for (int i = 0; i < 4 && rdy_out !== 1'b1; i++) @(negedge clk);
        chk(rdy_out === 1'b1, "R4 rdy returns", rdy_out, 1);
    endtask

    // CPU reads while strobe still low: no second capture.
    task automatic t_rx_early_read(input logic [DW-1:0] b);
        pin_din = b;
        dav_n_in = 1'b0;
        cycles(5);
        chk(rd_valid === 1'b1 && rd_data === b, "R2 early read byte", rd_data, b);
        cpu_read();
        cycles(6);
        chk(rd_valid === 1'b0, "R9 single capture", rd_valid, 0);
        chk(rdy_out === 1'b0, "R3 rdy low until dav rises", rdy_out, 0);
        dav_n_in = 1'b1;
        for (int i = 0; i < 5 && rdy_out !== 1'b1; i++) @(negedge clk);
        chk(rdy_out === 1'b1, "R4 rdy after dav rise", rdy_out, 1);
        chk(rd_valid === 1'b0, "R9 still empty", rd_valid, 0);
    endtask

    task automatic send_write(input logic [DW-1:0] b);
        for (int i = 0; i < 10 && wr_ready !== 1'b1; i++) @(negedge clk);
        chk(wr_ready === 1'b1, "R7 ready when idle", wr_ready, 1);
        wr_data = b;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_ready === 1'b0, "R7 busy after accept", wr_ready, 0);
    endtask

    task automatic t_tx_byte(input logic [DW-1:0] b);
        send_write(b);
        chk(pin_dout === b && dav_n_out === 1'b1, "R5 data before strobe", pin_dout, b);
        for (int i = 0; i < 6 && dav_n_out !== 1'b0; i++) @(negedge clk);
        chk(dav_n_out === 1'b0, "R6 strobe low", dav_n_out, 0);
        chk(pin_dout === b, "R5 data during strobe", pin_dout, b);
        cycles(6);
        chk(dav_n_out === 1'b0, "R6 strobe held while rdy high", dav_n_out, 0);
        rdy_in = 1'b0;
        for (int i = 0; i < 4 && dav_n_out !== 1'b1; i++) @(negedge clk);
        chk(dav_n_out === 1'b1, "R6 strobe released", dav_n_out, 1);
        cycles(6);
        chk(wr_ready === 1'b0, "R7 busy until rdy rises", wr_ready, 0);
        rdy_in = 1'b1;
        for (int i = 0; i < 5 && wr_ready !== 1'b1; i++) @(negedge clk);
        chk(wr_ready === 1'b1, "R7 idle after rdy rise", wr_ready, 1);
    endtask

    task automatic t_tx_blocked(input logic [DW-1:0] b);
        rdy_in = 1'b0;
        cycles(3);
        send_write(b);
        cycles(8);
        chk(dav_n_out === 1'b1, "R7 strobe waits for rdy", dav_n_out, 1);
        chk(pin_dout === b, "R5 data driven early", pin_dout, b);
        rdy_in = 1'b1;
        for (int i = 0; i < 5 && dav_n_out !== 1'b0; i++) @(negedge clk);
        chk(dav_n_out === 1'b0, "R7 strobe after rdy rise", dav_n_out, 0);
        rdy_in = 1'b0;
        for (int i = 0; i < 5 && dav_n_out !== 1'b1; i++) @(negedge clk);
        rdy_in = 1'b1;
        cycles(5);
    endtask

    task automatic t_mode_send();
        chk(pin_oe === 1'b1, "R8 oe in send mode", pin_oe, 1);
        pin_din = 8'h3C;
        dav_n_in = 1'b0;
        cycles(6);
        chk(rd_valid === 1'b0, "R8 no capture in send mode", rd_valid, 0);
        chk(rdy_out === 1'b1, "R8 rdy_out high in send mode", rdy_out, 1);
        dav_n_in = 1'b1;
        cycles(4);
    endtask

    task automatic t_mode_recv();
        chk(pin_oe === 1'b0, "R8 oe in receive mode", pin_oe, 0);
        wr_valid = 1'b1;
        wr_data = 8'h77;
        cycles(4);
        chk(wr_ready === 1'b0, "R8 no write in receive mode", wr_ready, 0);
        chk(dav_n_out === 1'b1, "R8 no strobe in receive mode", dav_n_out, 1);
        wr_valid = 1'b0;
        cycles(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        t_reset();
        t_rx_byte(8'hA5);
        t_rx_byte(8'h00);
        t_rx_early_read(8'hFF);
        t_mode_recv();
        mode_out = 1'b1;
        cycles(2);
        t_tx_byte(8'h5A);
        t_tx_byte(8'h81);
        t_tx_blocked(8'hC3);
        t_mode_send();
        mode_out = 1'b0;
        cycles(4);
        t_rx_byte(8'h42);
        finish_run();
    end
endmodule